// File: doc/BRIEF.md
# Buffered Parallel-to-Serial Converter

This block takes a parallel word and sends it out one bit at a time. A capture register holds the word, and a separate shift chain does the shifting. The capture register samples the parallel inputs when its capture strobe rises. The shift chain can be zeroed, can be filled from the capture register, or can move one place on each rising edge of its shift strobe. Each shift puts a serial input bit into the first stage, and the serial output always shows the last stage. Because capture and shifting are decoupled, a new word can be sampled while the previous one is still going out. A separate load control then moves the new word into the chain.

Both strobes are ordinary data inputs sampled on a single system clock. A rising edge is detected when a strobe is high in a cycle and was low in the cycle before. The zero and load controls are active low. They act on every system clock edge in which they are asserted. A synchronous active-high reset zeroes all state, independently of the functional zero control.

Top module: `latched_piso`

## Requirements
- R1: On a system clock edge where `cap_strobe` is high and was low at the previous edge, the capture register takes `par_in`.
- R2: Without such a rising capture strobe, the capture register keeps its value, whatever `par_in`, `zero_n`, `fill_n` and `shift_strobe` do.
- R3: On a system clock edge with `zero_n` low, every stage of the shift chain becomes 0, whatever `shift_strobe` does.
- R4: On a system clock edge with `zero_n` high and `fill_n` low, the shift chain takes the capture register contents, not the live `par_in`. Bit `par_in[0]` maps to the first stage and `par_in[WIDTH-1]` maps to the last stage.
- R5: With `zero_n` and `fill_n` high, a rising `shift_strobe` moves `ser_in` into the first stage, and each other stage takes the stage before it. `ser_out` always equals the last stage, so a filled word leaves most significant bit first.
- R6: With `zero_n` and `fill_n` high and no rising `shift_strobe`, the shift chain holds its state. A strobe held high for several cycles gives exactly one shift.
- R7: When `zero_n` and `fill_n` are both low, zeroing wins and the chain becomes all zeros.
- R8: When a rising capture strobe and a fill happen at the same edge, the chain receives the capture register value from before that edge. The new word can be filled one cycle later.
- R9: A synchronous reset (`rst` high) zeroes the capture register, the shift chain and both edge detectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | WIDTH | Parallel word to capture |
| cap_strobe | input | 1 | Capture strobe; its rising edge samples `par_in` |
| shift_strobe | input | 1 | Shift strobe; its rising edge moves the chain one place |
| zero_n | input | 1 | Active-low chain zero, highest priority |
| fill_n | input | 1 | Active-low fill of the chain from the capture register |
| ser_in | input | 1 | Serial bit entering the first stage |
| ser_out | output | 1 | Last stage of the shift chain |

## Verification
The hardest case to reach from the ports is the one where capture and fill fall on the same edge. The only output is one serial bit, so the bench must tell the old captured word from the new one purely from the sequence of bits shifted out afterwards. The stimulus first captures and fills a known word. It then raises the capture strobe with a very different `par_in` in the same cycle as a fill. It shifts all bits out and expects the old word, then fills again and expects the new one. The bench also checks that a held-high shift strobe shifts only once, and that the capture register survives zeroing and shifting. Both checks use fill-then-shift-out readback.

// File: rtl/latched_piso_pkg.sv
package latched_piso_pkg;

    // Operation applied to the shift chain in one system cycle
    typedef enum logic [1:0] {
        CH_HOLD  = 2'd0,
        CH_SHIFT = 2'd1,
        CH_FILL  = 2'd2,
        CH_ZERO  = 2'd3
    } chain_op_e;

    // Control inputs seen by the chain after edge detection
    typedef struct packed {
        logic zero_n;
        logic fill_n;
        logic shift_rise;
    } chain_ctrl_t;

    // Index of each strobe in the edge-detector bank
    localparam int STB_CAP   = 0;
    localparam int STB_SHIFT = 1;
    localparam int N_STB     = 2;

    // Zero beats fill, fill beats shift, otherwise hold
    function automatic chain_op_e decode_op(input chain_ctrl_t c);
        chain_op_e op;
        if (!c.zero_n)
            op = CH_ZERO;
        else if (!c.fill_n)
            op = CH_FILL;
        else if (c.shift_rise)
            op = CH_SHIFT;
        else
            op = CH_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else
            prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/capture_bank.sv
module capture_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (cap_en)
            q <= d;
    end
endmodule

// File: rtl/shift_chain.sv
module shift_chain
    import latched_piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  chain_op_e        op,
    input  logic [WIDTH-1:0] fill_word,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] nxt;

    // Stage k+1 takes stage k; stage 0 takes the serial input
    always_comb begin
        nxt = q;
        unique case (op)
            CH_ZERO:  nxt = '0;
            CH_FILL:  nxt = fill_word;
            CH_SHIFT: nxt = {q[LAST-1:0], ser_in};
            default:  nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end
endmodule

// File: rtl/latched_piso.sv
module latched_piso
    import latched_piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] par_in,
    input  logic             cap_strobe,
    input  logic             shift_strobe,
    input  logic             zero_n,
    input  logic             fill_n,
    input  logic             ser_in,
    output logic             ser_out
);
    localparam int LAST = WIDTH - 1;

    logic [N_STB-1:0] stb_lvl;
    logic [N_STB-1:0] stb_rise;
    logic [WIDTH-1:0] st_q;
    logic [WIDTH-1:0] sr_q;
    chain_ctrl_t      ctrl;
    chain_op_e        op;

    assign stb_lvl[STB_CAP]   = cap_strobe;
    assign stb_lvl[STB_SHIFT] = shift_strobe;

    for (genvar i = 0; i < N_STB; i++) begin : g_rise
        strobe_rise u_rise (
            .clk (clk),
            .rst (rst),
            .lvl (stb_lvl[i]),
            .rise(stb_rise[i])
        );
    end

    capture_bank #(.WIDTH(WIDTH)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .cap_en(stb_rise[STB_CAP]),
        .d     (par_in),
        .q     (st_q)
    );

    assign ctrl.zero_n     = zero_n;
    assign ctrl.fill_n     = fill_n;
    assign ctrl.shift_rise = stb_rise[STB_SHIFT];
    assign op              = decode_op(ctrl);

    shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .fill_word(st_q),
        .ser_in   (ser_in),
        .q        (sr_q)
    );

    assign ser_out = sr_q[LAST];
endmodule

// File: rtl/latched_piso_chk.sv
module latched_piso_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] par_in,
    input logic             cap_strobe,
    input logic             shift_strobe,
    input logic             zero_n,
    input logic             fill_n,
    input logic             ser_in,
    input logic             ser_out,
    input logic [WIDTH-1:0] st_q,
    input logic [WIDTH-1:0] sr_q
);
    logic cap_seen, shf_seen;
    logic cap_up, shf_up;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_seen <= 1'b0;
            shf_seen <= 1'b0;
        end else begin
            cap_seen <= cap_strobe;
            shf_seen <= shift_strobe;
        end
    end

    assign cap_up = cap_strobe & ~cap_seen;
    assign shf_up = shift_strobe & ~shf_seen;

    p_capture_r1: assert property (@(posedge clk) disable iff (rst)
        cap_up |=> st_q == $past(par_in));

    p_capture_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cap_up |=> $stable(st_q));

    p_zero_wins_r3_r7: assert property (@(posedge clk) disable iff (rst)
        !zero_n |=> (sr_q == '0) && !ser_out);

    p_fill_old_word_r4_r8: assert property (@(posedge clk) disable iff (rst)
        (zero_n && !fill_n) |=> sr_q == $past(st_q));

    p_shift_step_r5: assert property (@(posedge clk) disable iff (rst)
        (zero_n && fill_n && shf_up) |=>
            sr_q == {$past(sr_q[WIDTH-2:0]), $past(ser_in)});

    p_chain_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (zero_n && fill_n && !shf_up) |=> $stable(sr_q));

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (st_q == '0) && (sr_q == '0));
endmodule

bind latched_piso latched_piso_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .par_in      (par_in),
    .cap_strobe  (cap_strobe),
    .shift_strobe(shift_strobe),
    .zero_n      (zero_n),
    .fill_n      (fill_n),
    .ser_in      (ser_in),
    .ser_out     (ser_out),
    .st_q        (st_q),
    .sr_q        (sr_q)
);

// File: tb/test_latched_piso.sv
`timescale 1ns/1ps
module test_latched_piso;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] par_in = '0;
    logic         cap_strobe = 1'b0;
    logic         shift_strobe = 1'b0;
    logic         zero_n = 1'b1;
    logic         fill_n = 1'b1;
    logic         ser_in = 1'b0;
    logic         ser_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    latched_piso #(.WIDTH(W)) i_latched_piso (
        .clk(clk), .rst(rst), .par_in(par_in), .cap_strobe(cap_strobe),
        .shift_strobe(shift_strobe), .zero_n(zero_n), .fill_n(fill_n),
        .ser_in(ser_in), .ser_out(ser_out)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog got=%0d cycles exp=<100000", cycles);
            summary();
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [W-1:0] got, input logic [W-1:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic capture(input logic [W-1:0] word);
        par_in = word; cap_strobe = 1'b1; step();
        cap_strobe = 1'b0; step();
    endtask

    task automatic fill();
        fill_n = 1'b0; step(); fill_n = 1'b1;
    endtask

    task automatic shift1(input logic b);
        ser_in = b; shift_strobe = 1'b1; step();
        shift_strobe = 1'b0; step();
    endtask

    task automatic read_word(output logic [W-1:0] w);
        for (int i = 0; i < W; i++) begin
            w[W-1-i] = ser_out;
            shift1(1'b0);
        end
    endtask

    task automatic t_reset();
        logic [W-1:0] w;
        capture(8'hC3); fill();
        rst = 1'b1; step(); step(); rst = 1'b0; step();
        chk({7'b0, ser_out}, 8'h00, "R9 ser_out after reset");
        fill(); read_word(w);
        chk(w, 8'h00, "R9 capture register zero after reset");
    endtask

    task automatic t_capture_fill();
        logic [W-1:0] w;
        capture(8'hA5); fill();
        chk({7'b0, ser_out}, 8'h01, "R5 msb first after fill");
        read_word(w);
        chk(w, 8'hA5, "R1 R4 captured word shifted out");
    endtask

    task automatic t_not_live();
        logic [W-1:0] w;
        capture(8'h3C); par_in = 8'hFF; step(); fill(); read_word(w);
        chk(w, 8'h3C, "R4 fill uses capture register not par_in");
    endtask

    task automatic t_capture_hold();
        logic [W-1:0] w;
        capture(8'h96);
        par_in = 8'h00; zero_n = 1'b0; shift_strobe = 1'b1; step();
        zero_n = 1'b1; shift_strobe = 1'b0; par_in = 8'h7E; step();
        shift1(1'b1); shift1(1'b0);
        fill(); read_word(w);
        chk(w, 8'h96, "R2 capture register unchanged by chain activity");
    endtask

    task automatic t_zero();
        logic [W-1:0] w;
        capture(8'hFF); fill();
        zero_n = 1'b0; shift_strobe = 1'b1; ser_in = 1'b1; step();
        chk({7'b0, ser_out}, 8'h00, "R3 ser_out zero after zero_n");
        zero_n = 1'b1; shift_strobe = 1'b0; ser_in = 1'b0; step();
        read_word(w);
        chk(w, 8'h00, "R3 chain all zero");
    endtask

    task automatic t_precedence();
        logic [W-1:0] w;
        capture(8'hFF);
        zero_n = 1'b0; fill_n = 1'b0; step();
        zero_n = 1'b1; fill_n = 1'b1; step();
        read_word(w);
        chk(w, 8'h00, "R7 zero beats fill");
    endtask

    task automatic t_serial_in();
        logic [W-1:0] pat = 8'hC9;
        logic [W-1:0] w;
        zero_n = 1'b0; step(); zero_n = 1'b1;
        for (int i = W - 1; i >= 0; i--) shift1(pat[i]);
        read_word(w);
        chk(w, pat, "R5 serial input order");
    endtask

    task automatic t_hold();
        logic [W-1:0] w;
        capture(8'h81); fill();
        ser_in = 1'b0; shift_strobe = 1'b1;
        for (int i = 0; i < 5; i++) step();
        shift_strobe = 1'b0; step(); step();
        chk({7'b0, ser_out}, 8'h00, "R6 single shift ser_out");
        read_word(w);
        chk(w, 8'h02, "R6 held strobe shifts once");
    endtask

    task automatic t_same_cycle();
        logic [W-1:0] w;
        capture(8'h11);
        par_in = 8'hEE; cap_strobe = 1'b1; fill_n = 1'b0; step();
        cap_strobe = 1'b0; fill_n = 1'b1; step();
        read_word(w);
        chk(w, 8'h11, "R8 same-edge fill gets old word");
        fill(); read_word(w);
        chk(w, 8'hEE, "R8 R1 new word fillable next cycle");
    endtask

    initial begin
        step(); step(); rst = 1'b0; step();
        chk({7'b0, ser_out}, 8'h00, "R9 initial ser_out");
        t_capture_fill();
        t_not_live();
        t_capture_hold();
        t_zero();
        t_precedence();
        t_serial_in();
        t_hold();
        t_same_cycle();
        t_reset();
        done = 1'b1;
        summary();
    end
endmodule